// File: doc/BRIEF.md
# Parallel display bus master

This block drives an 8-bit parallel display interface with separate, active-low write and read strobes. It takes one request at a time from a host over a valid/ready port and turns it into a sequence of bus cycles. Each cycle has its own chip-select, data/command select and strobe timing. The bus is split into an output byte, an output enable and an input byte, so the pad ring can build the bidirectional pins from them.

Supported requests:
- command and data writes of one or two bytes;
- pixel fills, which repeat one 16-bit pixel a given number of times;
- pixel readback, either raw 16-bit or converted from 18-bit colour to RGB565;
- 32-bit register reads;
- indexed register writes and reads, which use a 16-bit index with a zero high byte;
- a timed panel reset.

Strobe low time, strobe high time, read sample point and the three reset phases are parameters counted in clocks. Read results return with a one-cycle valid pulse.

Top module: `pbus_master`

## Requirements
- R1: After `rst`, the outputs are as follows, and this is also the idle state:
  - `lcd_wr_n`, `lcd_rd_n`, `lcd_dc` and `lcd_rst_n` are 1;
  - `lcd_d_oe` is 1;
  - `req_ready` is 1, `busy` is 0 and `rsp_valid` is 0;
  - `lcd_cs_n` equals the inverse of `bus_en` except during the forced-high windows of R8 and R12.
- R2: A command write sends its bytes with `lcd_dc`=0: one byte `req_word[7:0]` for op 0, or `req_word[15:8]` then `req_word[7:0]` for op 1. `lcd_dc` is back at 1 once the request completes.
- R3: A data write sends its bytes with `lcd_dc`=1: one byte `req_word[7:0]` for op 2, or the high byte then the low byte of `req_word` for op 3.
- R4: Every byte is written by one low pulse of `lcd_wr_n` lasting exactly T_LOW clocks. `lcd_d_out` and `lcd_dc` do not change while the strobe is low, and the two strobes are never low together.
- R5: A fill (op 4) sends `req_word` `req_count` times, high byte then low byte, with `lcd_dc`=1. A count of 0 produces no strobe and completes.
- R6: A pixel readback (op 5) with `req_convert`=0 performs one discarded read followed by reads of bytes A and B. It returns `rsp_data` = {16'h0, A, B}.
- R7: A pixel readback with `req_convert`=1 performs one discarded read followed by reads of bytes R, G and B. It returns {16'h0, R[7:3], G[7:2], B[7:3]}.
- R8: A register read (op 6) proceeds as follows:
  - it writes `req_word[7:0]` with `lcd_dc`=0;
  - it performs one discarded read;
  - it reads four bytes and returns them first byte most significant;
  - it then drives `lcd_cs_n` high for T_HIGH clocks before completing.
- R9: An indexed write (op 7) sends 8'h00 and then `req_word[7:0]` with `lcd_dc`=0. It then sends the high byte and then the low byte of `req_data` with `lcd_dc`=1.
- R10: An indexed read (op 8) sends 8'h00 and then `req_word[7:0]` with `lcd_dc`=0. It then reads two bytes with no discarded read and returns {16'h0, first, second}.
- R11: `lcd_d_oe` is 0 at least one clock before the first read strobe of a request and returns to 1 after the last one. `lcd_d_oe` is 0 whenever `lcd_rd_n` is low and 1 whenever `lcd_wr_n` is low.
- R12: A reset request (op 9) holds `lcd_cs_n` high and `lcd_rst_n` high for T_RST_PRE clocks. It then drives `lcd_rst_n` low for exactly T_RST_LOW clocks, then high for T_RST_POST clocks. `req_ready` stays 0 for the whole sequence.
- R13: A request is taken when `req_valid` and `req_ready` are both 1. `req_ready` is 0 and `busy` is 1 until the request completes. Reads (ops 5, 6 and 8) complete with `rsp_valid` high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Enables the panel; drives chip-select low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_op | input | 4 | Operation code (0..9, see requirements) |
| req_word | input | 16 | Command, data, pixel or register number |
| req_data | input | 16 | Indexed write data |
| req_count | input | CNT_W | Fill pixel count |
| req_convert | input | 1 | Pixel readback converts to RGB565 |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle read result valid |
| rsp_data | output | 32 | Read result |
| lcd_cs_n | output | 1 | Chip-select, active low |
| lcd_dc | output | 1 | 0 = command byte, 1 = data byte |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_d_out | output | 8 | Bus byte driven by the master |
| lcd_d_oe | output | 1 | Master drives the bus when 1 |
| lcd_d_in | input | 8 | Bus byte driven by the panel |

## Verification
A byte counter that slips shows up at once in the bus byte stream: a byte is missing, repeated or out of order, or `lcd_dc` has the wrong level on the strobe that follows. A fault in the read path shows up on the single `rsp_valid` cycle as a shifted or unconverted value. The same fault also appears at the next read strobe as `lcd_d_oe` still high. A wrong phase in the reset timer shows as a low pulse of the wrong length on `lcd_rst_n`, or as `req_ready` rising too early.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [3:0] {
        OP_CMD8  = 4'd0,
        OP_CMD16 = 4'd1,
        OP_DAT8  = 4'd2,
        OP_DAT16 = 4'd3,
        OP_FILL  = 4'd4,
        OP_PIXRD = 4'd5,
        OP_REG32 = 4'd6,
        OP_IDXWR = 4'd7,
        OP_IDXRD = 4'd8,
        OP_HWRST = 4'd9
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WR, ST_TURN, ST_RD, ST_CSP, ST_RST, ST_DONE
    } st_e;

    typedef enum logic [1:0] {
        SP_IDLE, SP_LOW, SP_HIGH
    } strobe_ph_e;

    typedef enum logic [1:0] {
        RP_IDLE, RP_PRE, RP_LOW, RP_POST
    } rst_ph_e;

    typedef struct packed {
        op_e         op;
        logic [15:0] word;
        logic [15:0] data;
        logic        conv;
    } req_t;

    // number of write strobes a request issues before any read
    function automatic logic [16:0] wr_count(op_e op, logic [15:0] cnt);
        case (op)
            OP_CMD8, OP_DAT8, OP_REG32:  return 17'd1;
            OP_CMD16, OP_DAT16, OP_IDXRD: return 17'd2;
            OP_IDXWR:                    return 17'd4;
            OP_FILL:                     return {cnt, 1'b0};
            default:                     return 17'd0;
        endcase
    endfunction

    // number of read strobes, discarded read included
    function automatic logic [2:0] rd_count(op_e op, logic conv);
        case (op)
            OP_PIXRD: return conv ? 3'd4 : 3'd3;
            OP_REG32: return 3'd5;
            OP_IDXRD: return 3'd2;
            default:  return 3'd0;
        endcase
    endfunction

    function automatic logic has_dummy(op_e op);
        return (op == OP_PIXRD) || (op == OP_REG32);
    endfunction

    function automatic logic [7:0] wr_byte(op_e op, logic [15:0] word,
                                           logic [15:0] data, logic [1:0] k);
        case (op)
            OP_CMD16, OP_DAT16, OP_FILL: return k[0] ? word[7:0] : word[15:8];
            OP_IDXWR, OP_IDXRD: begin
                case (k)
                    2'd0:    return 8'h00;
                    2'd1:    return word[7:0];
                    2'd2:    return data[15:8];
                    default: return data[7:0];
                endcase
            end
            default: return word[7:0];
        endcase
    endfunction

    function automatic logic dc_level(op_e op, logic k1);
        case (op)
            OP_CMD8, OP_CMD16, OP_REG32: return 1'b0;
            OP_IDXWR, OP_IDXRD:          return k1;
            default:                     return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pbus_strobe.sv
module pbus_strobe
    import pbus_pkg::*;
#(
    parameter int T_LOW    = 2,
    parameter int T_HIGH   = 2,
    parameter int T_SAMPLE = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       is_read,
    input  logic [7:0] din,
    output logic       wr_n,
    output logic       rd_n,
    output logic       done,
    output logic [7:0] rdata
);
    localparam int TMAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
    localparam int CW   = $clog2(TMAX + 1);

    strobe_ph_e    ph;
    logic [CW-1:0] cnt;
    logic          rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= SP_IDLE;
            cnt   <= '0;
            rd_q  <= 1'b0;
            rdata <= '0;
        end else begin
            case (ph)
                SP_IDLE: if (start) begin
                    ph   <= SP_LOW;
                    cnt  <= '0;
                    rd_q <= is_read;
                end
                SP_LOW: begin
                    if (rd_q && cnt == CW'(T_SAMPLE)) rdata <= din;
                    if (cnt == CW'(T_LOW - 1)) begin
                        ph  <= SP_HIGH;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SP_HIGH: begin
                    if (cnt == CW'(T_HIGH - 1)) ph <= SP_IDLE;
                    else                       cnt <= cnt + 1'b1;
                end
                default: ph <= SP_IDLE;
            endcase
        end
    end

    assign wr_n = !(ph == SP_LOW && !rd_q);
    assign rd_n = !(ph == SP_LOW && rd_q);
    assign done = (ph == SP_HIGH) && (cnt == CW'(T_HIGH - 1));

endmodule

// File: rtl/pbus_rstseq.sv
module pbus_rstseq
    import pbus_pkg::*;
#(
    parameter int T_PRE  = 750000,
    parameter int T_LOW  = 100000,
    parameter int T_POST = 5000000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic rst_n,
    output logic done
);
    localparam int M1 = (T_PRE > T_LOW) ? T_PRE : T_LOW;
    localparam int TMAX = (M1 > T_POST) ? M1 : T_POST;
    localparam int CW = $clog2(TMAX + 1);

    rst_ph_e       ph;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= RP_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                RP_IDLE: if (start) begin
                    ph  <= RP_PRE;
                    cnt <= '0;
                end
                RP_PRE: if (cnt == CW'(T_PRE - 1)) begin
                    ph  <= RP_LOW;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                RP_LOW: if (cnt == CW'(T_LOW - 1)) begin
                    ph  <= RP_POST;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                RP_POST: if (cnt == CW'(T_POST - 1)) ph <= RP_IDLE;
                         else cnt <= cnt + 1'b1;
                default: ph <= RP_IDLE;
            endcase
        end
    end

    assign rst_n = (ph != RP_LOW);
    assign done  = (ph == RP_POST) && (cnt == CW'(T_POST - 1));

endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbus_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int T_LOW      = 2,
    parameter int T_HIGH     = 2,
    parameter int T_SAMPLE   = 1,
    parameter int T_RST_PRE  = 750000,
    parameter int T_RST_LOW  = 100000,
    parameter int T_RST_POST = 5000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_en,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_op,
    input  logic [15:0]      req_word,
    input  logic [15:0]      req_data,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_convert,
    output logic             busy,
    output logic             rsp_valid,
    output logic [31:0]      rsp_data,
    output logic             lcd_cs_n,
    output logic             lcd_dc,
    output logic             lcd_wr_n,
    output logic             lcd_rd_n,
    output logic             lcd_rst_n,
    output logic [7:0]       lcd_d_out,
    output logic             lcd_d_oe,
    input  logic [7:0]       lcd_d_in
);
    localparam int NW  = CNT_W + 1;
    localparam int CSW = $clog2(T_HIGH + 1);

    st_e            state;
    req_t           rq;
    logic [NW-1:0]  nwr_q, k;
    logic [2:0]     nrd_q, rk;
    logic           inflight;
    logic [31:0]    acc;
    logic [CSW-1:0] csp_cnt;

    op_e            op_in;
    logic [NW-1:0]  nwr_in;
    logic [2:0]     nrd_in;
    logic           accept, issue;
    logic           eng_done;
    logic [7:0]     eng_rdata;
    logic           rs_done;
    logic [31:0]    result;

    assign op_in     = op_e'(req_op);
    assign nwr_in    = NW'(wr_count(op_in, 16'(req_count)));
    assign nrd_in    = rd_count(op_in, req_convert);
    assign req_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign issue     = (state == ST_WR || state == ST_RD) && !inflight;
    assign lcd_cs_n  = !bus_en || state == ST_CSP || state == ST_RST;

    pbus_strobe #(.T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_SAMPLE(T_SAMPLE)) u_strobe (
        .clk(clk), .rst(rst), .start(issue), .is_read(state == ST_RD),
        .din(lcd_d_in), .wr_n(lcd_wr_n), .rd_n(lcd_rd_n),
        .done(eng_done), .rdata(eng_rdata)
    );

    pbus_rstseq #(.T_PRE(T_RST_PRE), .T_LOW(T_RST_LOW), .T_POST(T_RST_POST)) u_rstseq (
        .clk(clk), .rst(rst), .start(accept && op_in == OP_HWRST),
        .rst_n(lcd_rst_n), .done(rs_done)
    );

    always_comb begin
        case (rq.op)
            OP_PIXRD: result = rq.conv ? {16'h0, acc[23:19], acc[15:10], acc[7:3]}
                                       : {16'h0, acc[15:0]};
            OP_REG32: result = acc;
            OP_IDXRD: result = {16'h0, acc[15:0]};
            default:  result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rq        <= '0;
            nwr_q     <= '0;
            nrd_q     <= '0;
            k         <= '0;
            rk        <= '0;
            inflight  <= 1'b0;
            acc       <= '0;
            csp_cnt   <= '0;
            lcd_dc    <= 1'b1;
            lcd_d_oe  <= 1'b1;
            lcd_d_out <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    rq       <= '{op: op_in, word: req_word, data: req_data, conv: req_convert};
                    nwr_q    <= nwr_in;
                    nrd_q    <= nrd_in;
                    k        <= '0;
                    rk       <= '0;
                    acc      <= '0;
                    inflight <= 1'b0;
                    if (op_in == OP_HWRST) begin
                        lcd_dc <= 1'b1;
                        state  <= ST_RST;
                    end else if (nwr_in != '0) begin
                        state <= ST_WR;
                    end else if (nrd_in != '0) begin
                        lcd_d_oe <= 1'b0;
                        state    <= ST_TURN;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_WR: begin
                    if (issue) begin
                        lcd_d_out <= wr_byte(rq.op, rq.word, rq.data, k[1:0]);
                        lcd_dc    <= dc_level(rq.op, k[1]);
                        inflight  <= 1'b1;
                    end else if (eng_done) begin
                        inflight <= 1'b0;
                        k        <= k + 1'b1;
                        if (k + 1'b1 == nwr_q) begin
                            lcd_dc <= 1'b1;
                            if (nrd_q != '0) begin
                                lcd_d_oe <= 1'b0;
                                state    <= ST_TURN;
                            end else begin
                                state <= ST_DONE;
                            end
                        end
                    end
                end
                ST_TURN: state <= ST_RD;
                ST_RD: begin
                    if (issue) begin
                        inflight <= 1'b1;
                    end else if (eng_done) begin
                        inflight <= 1'b0;
                        rk       <= rk + 1'b1;
                        if (!(has_dummy(rq.op) && rk == '0))
                            acc <= {acc[23:0], eng_rdata};
                        if (rk + 1'b1 == nrd_q) begin
                            lcd_d_oe <= 1'b1;
                            csp_cnt  <= '0;
                            state    <= (rq.op == OP_REG32) ? ST_CSP : ST_DONE;
                        end
                    end
                end
                ST_CSP: begin
                    if (csp_cnt == CSW'(T_HIGH - 1)) state <= ST_DONE;
                    else csp_cnt <= csp_cnt + 1'b1;
                end
                ST_RST: if (rs_done) state <= ST_DONE;
                ST_DONE: begin
                    rsp_valid <= (nrd_q != '0);
                    rsp_data  <= result;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pbus_chk.sv
module pbus_chk (
    input logic       clk,
    input logic       rst,
    input logic       lcd_wr_n,
    input logic       lcd_rd_n,
    input logic       lcd_d_oe,
    input logic [7:0] lcd_d_out,
    input logic       lcd_dc,
    input logic       lcd_rst_n,
    input logic       lcd_cs_n,
    input logic       rsp_valid,
    input logic       req_ready
);
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(!lcd_wr_n && !lcd_rd_n));

    assert_wr_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!lcd_wr_n && $past(!lcd_wr_n)) |-> ($stable(lcd_d_out) && $stable(lcd_dc)));

    assert_rd_oe_R11: assert property (@(posedge clk) disable iff (rst)
        !lcd_rd_n |-> !lcd_d_oe);

    assert_wr_oe_R11: assert property (@(posedge clk) disable iff (rst)
        !lcd_wr_n |-> lcd_d_oe);

    assert_rst_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !lcd_rst_n |-> (lcd_wr_n && lcd_rd_n && lcd_cs_n && lcd_dc && !req_ready));

    assert_rsp_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

bind pbus_master pbus_chk u_chk (
    .clk(clk), .rst(rst), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_d_oe(lcd_d_oe), .lcd_d_out(lcd_d_out), .lcd_dc(lcd_dc),
    .lcd_rst_n(lcd_rst_n), .lcd_cs_n(lcd_cs_n), .rsp_valid(rsp_valid),
    .req_ready(req_ready)
);

// File: tb/tb_pbus_master.sv
module tb_pbus_master;
    localparam int CLK_PERIOD = 10;
    localparam int P_LOW  = 3;
    localparam int P_HIGH = 2;
    localparam int P_SMP  = 2;
    localparam int P_RPRE = 20;
    localparam int P_RLOW = 6;
    localparam int P_RPOST = 30;

    logic clk = 0, rst = 1, bus_en = 0;
    logic req_valid = 0, req_ready, req_convert = 0, busy, rsp_valid;
    logic [3:0] req_op = 0;
    logic [15:0] req_word = 0, req_data = 0, req_count = 0;
    logic [31:0] rsp_data;
    logic lcd_cs_n, lcd_dc, lcd_wr_n, lcd_rd_n, lcd_rst_n, lcd_d_oe;
    logic [7:0] lcd_d_out, lcd_d_in = 0;

    int checks = 0, fails = 0;
    logic [8:0] exp_wr[$];
    logic [7:0] rd_src[$];
    logic [31:0] exp_rsp[$];
    logic wr_prev = 1, rd_prev = 1, cs_prev = 1;
    int wr_low = 0, cs_rises = 0, rst_low = 0, cs_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_master #(.T_LOW(P_LOW), .T_HIGH(P_HIGH), .T_SAMPLE(P_SMP),
                  .T_RST_PRE(P_RPRE), .T_RST_LOW(P_RLOW), .T_RST_POST(P_RPOST)) dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_word(req_word), .req_data(req_data), .req_count(req_count),
        .req_convert(req_convert), .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
        .lcd_rst_n(lcd_rst_n), .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: everything sampled on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (!lcd_wr_n && wr_prev) begin
                if (exp_wr.size() == 0) chk(0, "R2/R3 unexpected write", {23'h0, lcd_dc, lcd_d_out}, 0);
                else begin
                    logic [8:0] e;
                    e = exp_wr.pop_front();
                    chk({lcd_dc, lcd_d_out} == e, "R2/R3/R5/R9 write byte", {23'h0, lcd_dc, lcd_d_out}, {23'h0, e});
                end
                chk(lcd_d_oe == 1'b1, "R11 oe during write", {31'h0, lcd_d_oe}, 1);
            end
            if (!lcd_wr_n) wr_low++;
            else if (wr_low != 0) begin
                chk(wr_low == P_LOW, "R4 write strobe width", wr_low, P_LOW);
                wr_low = 0;
            end
            if (!lcd_rd_n && rd_prev) begin
                chk(lcd_d_oe == 1'b0, "R11 oe during read", {31'h0, lcd_d_oe}, 0);
                lcd_d_in <= (rd_src.size() != 0) ? rd_src.pop_front() : 8'h00;
            end
            if (bus_en && lcd_cs_n && !cs_prev && lcd_rst_n) cs_rises++;
            if (!lcd_rst_n) begin
                rst_low++;
                if (!lcd_cs_n) cs_bad++;
            end
            if (rsp_valid) begin
                if (exp_rsp.size() == 0) chk(0, "R13 unexpected response", rsp_data, 0);
                else begin
                    logic [31:0] e;
                    e = exp_rsp.pop_front();
                    chk(rsp_data == e, "R6/R7/R8/R10 read result", rsp_data, e);
                end
            end
        end
        wr_prev = lcd_wr_n;
        rd_prev = lcd_rd_n;
        cs_prev = lcd_cs_n;
    end

    task automatic send(input logic [3:0] op, input logic [15:0] w, input logic [15:0] d,
                        input logic [15:0] c, input logic cv);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_word = w; req_data = d; req_count = c; req_convert = cv;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic push_wr(input logic dc, input logic [7:0] b);
        exp_wr.push_back({dc, b});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c0, t0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(lcd_wr_n && lcd_rd_n && lcd_dc && lcd_rst_n, "R1 idle strobes", {28'h0, lcd_wr_n, lcd_rd_n, lcd_dc, lcd_rst_n}, 32'hF);
        chk(lcd_d_oe && req_ready && !busy && !rsp_valid, "R1 idle host side", {28'h0, lcd_d_oe, req_ready, busy, rsp_valid}, 32'hC);
        chk(lcd_cs_n == 1'b1, "R1 cs with bus_en=0", {31'h0, lcd_cs_n}, 1);
        bus_en = 1; #1;
        chk(lcd_cs_n == 1'b0, "R1 cs with bus_en=1", {31'h0, lcd_cs_n}, 0);

        // R2 command writes
        push_wr(0, 8'h2A);
        send(4'd0, 16'h002A, 0, 0, 0);
        chk(busy && !req_ready, "R13 busy during request", {30'h0, busy, req_ready}, 2);
        wait_idle();
        chk(lcd_dc == 1'b1, "R2 dc back high", {31'h0, lcd_dc}, 1);
        push_wr(0, 8'h12); push_wr(0, 8'h34);
        send(4'd1, 16'h1234, 0, 0, 0);
        // R3 data writes
        push_wr(1, 8'h5A);
        send(4'd2, 16'h005A, 0, 0, 0);
        push_wr(1, 8'hBE); push_wr(1, 8'hEF);
        send(4'd3, 16'hBEEF, 0, 0, 0);
        // R5 fills
        for (int i = 0; i < 3; i++) begin push_wr(1, 8'hF8); push_wr(1, 8'h00); end
        send(4'd4, 16'hF800, 0, 3, 0);
        for (int i = 0; i < 4; i++) push_wr(1, 8'h3C);
        send(4'd4, 16'h3C3C, 0, 2, 0);
        wait_idle();
        send(4'd4, 16'h1111, 0, 0, 0);
        wait_idle();
        chk(exp_wr.size() == 0 && req_ready, "R5 zero count fill", exp_wr.size(), 0);

        // R6 raw pixel readback
        rd_src.push_back(8'h99); rd_src.push_back(8'hAB); rd_src.push_back(8'hCD);
        exp_rsp.push_back(32'h0000ABCD);
        send(4'd5, 0, 0, 0, 0);
        wait_idle();
        chk(lcd_d_oe == 1'b1, "R11 oe restored", {31'h0, lcd_d_oe}, 1);
        // R7 converted readback
        rd_src.push_back(8'h77); rd_src.push_back(8'hFC); rd_src.push_back(8'h84); rd_src.push_back(8'h08);
        exp_rsp.push_back(32'h0000FC21);
        send(4'd5, 0, 0, 0, 1);
        wait_idle();

        // R8 register read
        c0 = cs_rises;
        push_wr(0, 8'h04);
        rd_src.push_back(8'h55); rd_src.push_back(8'h00); rd_src.push_back(8'h93);
        rd_src.push_back(8'h41); rd_src.push_back(8'hC0);
        exp_rsp.push_back(32'h009341C0);
        send(4'd6, 16'h0004, 0, 0, 0);
        wait_idle();
        chk(cs_rises - c0 == 1, "R8 chip-select pulse", cs_rises - c0, 1);

        // R9 indexed write
        push_wr(0, 8'h00); push_wr(0, 8'h22); push_wr(1, 8'hA5); push_wr(1, 8'hC3);
        send(4'd7, 16'h0022, 16'hA5C3, 0, 0);
        // R10 indexed read
        push_wr(0, 8'h00); push_wr(0, 8'h07);
        rd_src.push_back(8'h12); rd_src.push_back(8'h34);
        exp_rsp.push_back(32'h00001234);
        send(4'd8, 16'h0007, 0, 0, 0);
        wait_idle();

        // R12 reset sequence
        rst_low = 0; cs_bad = 0;
        send(4'd9, 0, 0, 0, 0);
        t0 = 1;
        while (!req_ready) begin @(negedge clk); t0++; end
        chk(rst_low == P_RLOW, "R12 reset low width", rst_low, P_RLOW);
        chk(t0 >= P_RPRE + P_RLOW + P_RPOST, "R12 ready held through sequence", t0, P_RPRE + P_RLOW + P_RPOST);
        chk(cs_bad == 0, "R12 chip-select high in reset", cs_bad, 0);
        chk(lcd_rst_n == 1'b1, "R12 reset released", {31'h0, lcd_rst_n}, 1);
        wait_idle();

        chk(exp_wr.size() == 0, "R2/R3 all writes seen", exp_wr.size(), 0);
        chk(exp_rsp.size() == 0, "R13 all responses seen", exp_rsp.size(), 0);
        chk(rd_src.size() == 0, "R6/R8 all reads used", rd_src.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule